// File: doc/BRIEF.md
# PCI Posted Write Buffer

This block sits between the target side of a PCI interface and the local memory bus. It takes memory-write bursts from an external PCI master, one data phase per handshake, and stores them in a 32-byte buffer of eight 32-bit beats. Once a beat is in the buffer, the PCI data phase is complete, even while local memory is still busy. The write is therefore posted. A drain engine then replays the buffered beats on the memory side, oldest first, as separate single-beat writes. Each write carries the address, data and active-low byte enables of its own beat.

Reads in either direction must not overtake posted writes. A read path raises `rd_req` and waits while `flush_busy` is high. The block holds `flush_busy` high until every buffered beat has been written out. New writes are refused while the flush is pending.

An internal conflict, signalled on `abort_req`, ends the current burst early. Beats that were already accepted stay valid and are still drained. The beat that meets the conflict is refused, and so is every later beat up to the end of that burst. Each refused beat is flagged on `wr_abort`. A sticky target-abort status bit records the event until it is cleared with a write-one pulse.

The ingress controller has three states:
- IN_IDLE goes to IN_BURST on an accepted beat that is not the last one.
- IN_BURST returns to IN_IDLE on an accepted last beat.
- Either state goes to IN_DISCARD on an aborted beat that is not the last one. An aborted last beat leaves the controller in IN_IDLE.
- IN_DISCARD returns to IN_IDLE on the last beat of the burst.

The drain controller has two states:
- DR_IDLE goes to DR_WRITE when the buffer is not empty.
- DR_WRITE stays in DR_WRITE while beats remain.
- DR_WRITE returns to DR_IDLE when the memory accepts the only remaining beat.

Top module: `pci_post_wbuf`

## Requirements
- R1: After reset, `wr_ready` is 1 and `mem_valid`, `flush_busy` and `ta_status` are all 0.
- R2: Every beat accepted with `wr_abort` low is written out exactly once, in acceptance order, as a single-beat memory write. That write carries the beat's own address, data and byte enables. `mem_be_n` bit i low enables data byte [8i+7:8i].
- R3: The buffer holds 8 beats (32 bytes). With memory stalled, 8 beats are accepted without waiting. A ninth data phase sees `wr_ready` low until a beat drains.
- R4: Once `mem_valid` is high, it stays high with `mem_addr`, `mem_data` and `mem_be_n` unchanged until `mem_ready` is high. One beat leaves the buffer per such handshake.
- R5: A beat presented with `abort_req` high is consumed (`wr_ready` high) with `wr_abort` high and is not stored. All later beats up to and including the one with `wr_last` are also consumed with `wr_abort` high and dropped. Beats accepted before the abort are still written out.
- R6: An aborted beat sets `ta_status` from the next cycle. `ta_status` then stays 1 until a cycle with `ta_clr` high and no new abort. If an abort and `ta_clr` occur in the same cycle, the bit stays set.
- R7: While `rd_req` is high and the buffer is not empty, `flush_busy` is high in the same cycle. It stays high after `rd_req` drops, until the buffer is empty. While `rd_req` or `flush_busy` is high, `wr_ready` is low.
- R8: A read request that arrives with the buffer empty leaves `flush_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | PCI write data phase present |
| wr_addr | input | 32 | Byte address of the beat |
| wr_data | input | 32 | Write data of the beat |
| wr_be_n | input | 4 | Active-low byte enables of the beat |
| wr_last | input | 1 | Beat is the final data phase of the burst |
| abort_req | input | 1 | Internal conflict: abort the burst at this beat |
| wr_ready | output | 1 | Data phase consumed this cycle |
| wr_abort | output | 1 | Consumed beat was aborted and dropped |
| ta_status | output | 1 | Sticky target-abort status |
| ta_clr | input | 1 | Write-one-to-clear pulse for `ta_status` |
| rd_req | input | 1 | A read in either direction is waiting |
| flush_busy | output | 1 | Posted writes still pending; the read must wait |
| mem_valid | output | 1 | Single-beat memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_be_n | output | 4 | Memory write active-low byte enables |
| mem_ready | input | 1 | Memory accepts the request |

## Verification
A wrong buffer pointer or count first shows up on the memory side. The next handshake delivers a beat with the wrong address, data or enables, or a beat is lost or repeated, and the scoreboard sees this at the first completed memory write after the fault. A wrong ingress state shows up as a mismatch on `wr_abort` at the very next data phase. It can also appear as aborted beats reaching memory, which is caught when they drain. A wrong flush flag shows up either as `flush_busy` falling while beats remain queued, or as `wr_ready` high during a pending read, both within one cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        IN_IDLE    = 2'd0,
        IN_BURST   = 2'd1,
        IN_DISCARD = 2'd2
    } ingress_state_e;

    typedef enum logic {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_state_e;

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
    parameter int W     = 68,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push) begin
            store[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = store[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R3: a write is never stored into a full buffer
    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R4: a memory handshake never consumes a beat from an empty buffer
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pwb_ingress.sv
module pwb_ingress
    import pwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic wr_last,
    input  logic abort_req,
    input  logic full,
    input  logic hold,
    output logic wr_ready,
    output logic wr_abort,
    output logic push,
    output logic abort_set
);
    ingress_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IN_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        wr_ready  = 1'b0;
        wr_abort  = 1'b0;
        push      = 1'b0;
        abort_set = 1'b0;
        unique case (state)
            IN_IDLE, IN_BURST: begin
                if (wr_valid && abort_req) begin
                    wr_ready  = 1'b1;
                    wr_abort  = 1'b1;
                    abort_set = 1'b1;
                    state_nx  = wr_last ? IN_IDLE : IN_DISCARD;
                end else begin
                    wr_ready = !full && !hold;
                    if (wr_valid && !full && !hold) begin
                        push     = 1'b1;
                        state_nx = wr_last ? IN_IDLE : IN_BURST;
                    end
                end
            end
            IN_DISCARD: begin
                wr_ready = 1'b1;
                wr_abort = 1'b1;
                if (wr_valid && wr_last) begin
                    state_nx = IN_IDLE;
                end
            end
            default: state_nx = IN_IDLE;
        endcase
    end

    // R5: an aborted beat is never written into the buffer
    a_r5_abort_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_abort) |-> !push);

    // R5: after an aborted non-final beat the next data phase is also refused
    a_r5_discard_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && abort_req && !wr_last) |=> wr_abort);

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
    import pwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic one_left,
    input  logic mem_ready,
    output logic mem_valid,
    output logic pop
);
    drain_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        mem_valid = 1'b0;
        pop       = 1'b0;
        unique case (state)
            DR_IDLE: begin
                if (!empty) begin
                    state_nx = DR_WRITE;
                end
            end
            DR_WRITE: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    pop = 1'b1;
                    if (one_left) begin
                        state_nx = DR_IDLE;
                    end
                end
            end
            default: state_nx = DR_IDLE;
        endcase
    end

    // R4: a pending memory request is held until accepted
    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid);

endmodule

// File: rtl/pci_post_wbuf.sv
module pci_post_wbuf #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be_n,
    input  logic                wr_last,
    input  logic                abort_req,
    output logic                wr_ready,
    output logic                wr_abort,
    output logic                ta_status,
    input  logic                ta_clr,
    input  logic                rd_req,
    output logic                flush_busy,
    output logic                mem_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_data,
    output logic [DATA_W/8-1:0] mem_be_n,
    input  logic                mem_ready
);
    localparam int BE_W  = DATA_W / 8;
    localparam int DEPTH = BUF_BYTES / BE_W;
    localparam int ENT_W = ADDR_W + DATA_W + BE_W;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             push, pop, full, empty, abort_set, hold;
    logic [ENT_W-1:0] head;
    logic [CW-1:0]    count;
    logic             flush_q, ta_q;

    assign hold = rd_req || flush_q;

    pwb_ingress u_ingress (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_last   (wr_last),
        .abort_req (abort_req),
        .full      (full),
        .hold      (hold),
        .wr_ready  (wr_ready),
        .wr_abort  (wr_abort),
        .push      (push),
        .abort_set (abort_set)
    );

    pwb_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({wr_addr, wr_data, wr_be_n}),
        .pop   (pop),
        .dout  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    pwb_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .empty     (empty),
        .one_left  (count == CW'(1)),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .pop       (pop)
    );

    assign mem_addr = head[ENT_W-1 -: ADDR_W];
    assign mem_data = head[BE_W +: DATA_W];
    assign mem_be_n = head[BE_W-1:0];

    // Flush flag: armed by a read against a non-empty buffer, released
    // on the edge where the last beat leaves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else begin
            flush_q <= (flush_q || rd_req) && !empty && !(pop && count == CW'(1));
        end
    end

    assign flush_busy = flush_q || (rd_req && !empty);

    // Sticky target-abort status, write-one-to-clear, set has priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta_q <= 1'b0;
        end else if (abort_set) begin
            ta_q <= 1'b1;
        end else if (ta_clr) begin
            ta_q <= 1'b0;
        end
    end

    assign ta_status = ta_q;

    // R7: the flush only ends with the buffer empty
    a_r7_flush_ends_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_q) |-> empty);

    // R7: no write enters the buffer while a read waits
    a_r7_no_write_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || flush_busy) |-> !push);

    // R8: a read may proceed only against an empty buffer
    a_r8_read_sees_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !flush_busy) |-> empty);

    // R6: the status bit holds without a clear pulse
    a_r6_ta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_status && !ta_clr) |=> ta_status);

    // R4: payload is frozen while memory stalls
    a_r4_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be_n)));

endmodule

// File: tb/tb_pci_post_wbuf.sv
`timescale 1ns/1ps
module tb_pci_post_wbuf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be_n = 4'hF;
    logic        wr_last = 1'b0;
    logic        abort_req = 1'b0;
    logic        wr_ready, wr_abort, ta_status, flush_busy, mem_valid;
    logic        ta_clr = 1'b0;
    logic        rd_req = 1'b0;
    logic [31:0] mem_addr, mem_data;
    logic [3:0]  mem_be_n;
    logic        mem_ready = 1'b0;

    int          errors = 0;
    int          checks = 0;
    int          last_waits;
    logic [67:0] exp_q [$];

    always #10 clk = ~clk;

    pci_post_wbuf dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be_n(wr_be_n), .wr_last(wr_last),
        .abort_req(abort_req), .wr_ready(wr_ready), .wr_abort(wr_abort),
        .ta_status(ta_status), .ta_clr(ta_clr), .rd_req(rd_req),
        .flush_busy(flush_busy), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be_n(mem_be_n), .mem_ready(mem_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Driver: presents one beat until consumed; predicts abort and queues
    // the expected memory write when the beat should be kept.
    task automatic send_beat(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] be, input bit last, input bit ab,
                             input bit exp_ab);
        bit done = 0;
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be_n = be;
        wr_last = last; abort_req = ab;
        last_waits = 0;
        while (!done) begin
            @(negedge clk);
            if (wr_ready) begin
                done = 1;
                chk(wr_abort == exp_ab, "R5", "wr_abort on beat", 68'(wr_abort), 68'(exp_ab));
                if (!exp_ab) exp_q.push_back({a, d, be});
            end else begin
                last_waits++;
            end
            tick();
        end
        wr_valid = 1'b0; wr_last = 1'b0; abort_req = 1'b0;
    endtask

    // Monitor: compares every memory handshake with the scoreboard and
    // checks that a stalled request is held unchanged.
    logic        prev_stall = 1'b0;
    logic [67:0] prev_req = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(mem_valid && ({mem_addr, mem_data, mem_be_n} == prev_req), "R4",
                    "stalled request held", {mem_addr, mem_data, mem_be_n}, prev_req);
            end
            prev_stall = mem_valid && !mem_ready;
            prev_req   = {mem_addr, mem_data, mem_be_n};
            if (mem_valid && mem_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected memory write", {mem_addr, mem_data, mem_be_n}, '0);
                end else begin
                    logic [67:0] e;
                    e = exp_q.pop_front();
                    chk({mem_addr, mem_data, mem_be_n} == e, "R2", "memory write",
                        {mem_addr, mem_data, mem_be_n}, e);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic drain_all();
        mem_ready = 1'b1;
        repeat (20) tick();
        chk(exp_q.size() == 0, "R2", "all beats written", 68'(exp_q.size()), 68'(0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wr_ready == 1'b1,   "R1", "wr_ready", 68'(wr_ready), 68'(1));
        chk(mem_valid == 1'b0,  "R1", "mem_valid", 68'(mem_valid), 68'(0));
        chk(flush_busy == 1'b0, "R1", "flush_busy", 68'(flush_busy), 68'(0));
        chk(ta_status == 1'b0,  "R1", "ta_status", 68'(ta_status), 68'(0));
        tick();

        // R2: short burst with mixed byte enables, memory free-running
        mem_ready = 1'b1;
        send_beat(32'h1000_0000, 32'hA1B2C3D4, 4'b0000, 0, 0, 0);
        send_beat(32'h1000_0004, 32'h11223344, 4'b1110, 0, 0, 0);
        send_beat(32'h1000_0008, 32'h55667788, 4'b0011, 0, 0, 0);
        send_beat(32'h1000_000C, 32'h99AABBCC, 4'b0111, 1, 0, 0);
        drain_all();

        // R3: fill with memory stalled, ninth phase must wait
        mem_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            send_beat(32'h2000_0000 + 32'(i * 4), 32'hC0DE_0000 + 32'(i), 4'(i), 0, 0, 0);
            chk(last_waits == 0, "R3", "beat accepted without wait", 68'(last_waits), 68'(0));
        end
        wr_valid = 1'b1; wr_addr = 32'h2000_0020; wr_data = 32'hC0DE_0008;
        wr_be_n = 4'b1010; wr_last = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(wr_ready == 1'b0, "R3", "ninth beat stalled", 68'(wr_ready), 68'(0));
        end
        tick();
        mem_ready = 1'b1;
        send_beat(32'h2000_0020, 32'hC0DE_0008, 4'b1010, 1, 0, 0);
        drain_all();

        // R5: abort mid-burst with memory stalled, then a fresh burst
        mem_ready = 1'b0;
        send_beat(32'h3000_0000, 32'hDEAD0001, 4'b0000, 0, 0, 0);
        send_beat(32'h3000_0004, 32'hDEAD0002, 4'b1100, 0, 0, 0);
        send_beat(32'h3000_0008, 32'hDEAD0003, 4'b0000, 0, 1, 1);
        send_beat(32'h3000_000C, 32'hDEAD0004, 4'b0000, 0, 0, 1);
        send_beat(32'h3000_0010, 32'hDEAD0005, 4'b0000, 1, 0, 1);
        @(negedge clk);
        chk(ta_status == 1'b1, "R6", "ta set by abort", 68'(ta_status), 68'(1));
        tick();
        send_beat(32'h3100_0000, 32'hBEEF0001, 4'b0101, 0, 0, 0);
        send_beat(32'h3100_0004, 32'hBEEF0002, 4'b1001, 1, 0, 0);
        drain_all();

        // R6: sticky, clear, set wins over clear
        repeat (4) tick();
        @(negedge clk);
        chk(ta_status == 1'b1, "R6", "ta sticky", 68'(ta_status), 68'(1));
        tick();
        ta_clr = 1'b1; tick(); ta_clr = 1'b0;
        @(negedge clk);
        chk(ta_status == 1'b0, "R6", "ta cleared", 68'(ta_status), 68'(0));
        tick();
        ta_clr = 1'b1;
        send_beat(32'h3200_0000, 32'h0BAD0BAD, 4'b0000, 1, 1, 1);
        ta_clr = 1'b0;
        @(negedge clk);
        chk(ta_status == 1'b1, "R6", "set wins over clear", 68'(ta_status), 68'(1));
        tick();
        ta_clr = 1'b1; tick(); ta_clr = 1'b0;
        @(negedge clk);
        chk(ta_status == 1'b0, "R6", "ta cleared again", 68'(ta_status), 68'(0));
        tick();

        // R7: read waits for posted writes
        mem_ready = 1'b0;
        send_beat(32'h4000_0000, 32'h0F0F0F0F, 4'b0000, 0, 0, 0);
        send_beat(32'h4000_0004, 32'hF0F0F0F0, 4'b0110, 0, 0, 0);
        send_beat(32'h4000_0008, 32'h12345678, 4'b1000, 1, 0, 0);
        rd_req = 1'b1;
        @(negedge clk);
        chk(flush_busy == 1'b1, "R7", "flush_busy on read", 68'(flush_busy), 68'(1));
        chk(wr_ready == 1'b0,   "R7", "writes held on read", 68'(wr_ready), 68'(0));
        tick();
        rd_req = 1'b0;
        wr_valid = 1'b1; wr_addr = 32'h4000_000C; wr_data = 32'h77777777; wr_last = 1'b1;
        @(negedge clk);
        chk(flush_busy == 1'b1, "R7", "flush_busy after read drop", 68'(flush_busy), 68'(1));
        chk(wr_ready == 1'b0,   "R7", "writes held during flush", 68'(wr_ready), 68'(0));
        tick();
        wr_valid = 1'b0; wr_last = 1'b0;
        mem_ready = 1'b1;
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
                if (flush_busy) tick();
            end while (flush_busy && n < 50);
        end
        chk(exp_q.size() == 0, "R7", "buffer empty when flush ends", 68'(exp_q.size()), 68'(0));
        chk(mem_valid == 1'b0, "R7", "no request after flush", 68'(mem_valid), 68'(0));
        tick();

        // R8: read against an empty buffer
        rd_req = 1'b1;
        @(negedge clk);
        chk(flush_busy == 1'b0, "R8", "no flush on empty buffer", 68'(flush_busy), 68'(0));
        tick();
        rd_req = 1'b0;
        repeat (3) tick();
        chk(exp_q.size() == 0, "R2", "scoreboard empty at end", 68'(exp_q.size()), 68'(0));
        finish_run();
    end

endmodule